// File: doc/BRIEF.md
# Two-Stage SPI Bit-Clock Divider

This block derives the serial bit clock of an SPI master from the system clock. It divides in two stages. An even prescaler comes first. A post-divider follows it and counts prescaler wraps. The overall ratio between the system clock and SCLK is the prescaler value times one plus the post value. The prescaler must be even and lie between 2 and 254. The post value may be anything from 0 to 255, so the ratio runs from 2 up to 65024.

The block produces two outputs. The first is a single-cycle `tick` that pulses at twice the SCLK rate, which a shift engine can use to time its launch and capture edges. The second is a free-running `sclk` that toggles on every tick and so has a 50% duty cycle. Prescaler values that are out of range are made legal inside the block. While `en` is low, both counters are held cleared and `sclk` sits at its idle level, low. Raising `en` therefore always starts a fresh half-period.

Top module: `spi_clk_divider`

## Requirements
- R1: After a synchronous reset, `tick` and `sclk` are both 0.
- R2: On the clock edge that samples `en` low, `tick` and `sclk` both go to 0, even if `sclk` was high.
- R3: With fields held stable and `en` high, `tick` pulses for exactly one cycle every H cycles, where H = (1 + post) × P / 2 and P is the effective prescaler. The first pulse appears after the H-th edge that samples `en` high.
- R4: `sclk` toggles on exactly the edges that raise `tick`, so after k enabled edges its value is floor(k / H) mod 2, and its period is 2H = (1 + post) × P cycles.
- R5: The effective prescaler P is the 8-bit `pre_field` with its bit 0 cleared. Any result below 2 (the raw values 0 and 1) is taken as 2, so every odd raw value acts as the next lower even value and 255 acts as 254.
- R6: Every `post_field` value from 0 to 255 multiplies the half-period by (1 + post).
- R7: The minimum ratio, 2, arises for P = 2 and post = 0. In that case `tick` stays high on every enabled cycle and `sclk` toggles every cycle.
- R8: The maximum ratio, 65024, arises for raw prescaler 254 or 255 with post = 255. The first tick then comes 32512 cycles after enabling.
- R9: Dropping `en` and raising it again discards any partial count, and the next tick comes a full H cycles after re-enabling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Divider run enable; low clears counters and idles SCLK |
| pre_field | input | 8 | Raw prescaler value (legalised to even, 2..254) |
| post_field | input | 8 | Post-divider value, ratio factor 1 + post |
| tick | output | 1 | Registered one-cycle pulse at twice the SCLK rate |
| sclk | output | 1 | Registered bit clock, idle low, 50% duty |

## Verification
The assertions assume that `pre_field` and `post_field` do not change while `en` is high. The checker's gap counter compares each tick interval against a product computed from the live field values, so a mid-run change would break that comparison. The bench therefore writes new field values only while `en` is low, and it keeps `en` low for at least one edge before each run. It sweeps every prescaler value with post 0 and every post value with the smallest prescaler. It also runs the extreme ratio and a drop-and-restart sequence taken while `sclk` is high. Every cycle's outputs are compared with floor arithmetic on the count of enabled edges.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  // Width of each divider field
  localparam int unsigned FIELD_W = 8;

  // Half of the legalised prescaler: even-rounded down, never below 2
  function automatic logic [FIELD_W-2:0] pre_half(input logic [FIELD_W-1:0] raw);
    logic [FIELD_W-2:0] h;
    h = raw[FIELD_W-1:1];
    if (h == '0) h = 1;
    return h;
  endfunction
endpackage

// File: rtl/div_pre_legalize.sv
module div_pre_legalize #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] raw,
  output logic [W-2:0] half
);
  // Dropping bit 0 rounds odd values down; zero half maps to the minimum of 1
  always_comb begin
    half = raw[W-1:1];
    if (half == '0) half = {{(W-2){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/div_stage.sv
module div_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] limit,
  output logic         wrap
);
  logic [W-1:0] cnt;

  assign wrap = adv && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (adv)
      cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/spi_clk_divider.sv
module spi_clk_divider #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned POST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PRE_W-1:0]  pre_field,
  input  logic [POST_W-1:0] post_field,
  output logic              tick,
  output logic              sclk
);
  localparam int unsigned HALF_W = PRE_W - 1;

  logic [HALF_W-1:0] pre_half;
  logic [HALF_W-1:0] pre_limit;
  logic              pre_wrap;
  logic              post_wrap;

  div_pre_legalize #(.W(PRE_W)) u_legal (
    .raw  (pre_field),
    .half (pre_half)
  );

  assign pre_limit = pre_half - 1'b1;

  // First stage: wraps every P/2 enabled cycles
  div_stage #(.W(HALF_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clr   (!en),
    .adv   (en),
    .limit (pre_limit),
    .wrap  (pre_wrap)
  );

  // Second stage: wraps after 1 + post first-stage wraps
  div_stage #(.W(POST_W)) u_post (
    .clk   (clk),
    .rst   (rst),
    .clr   (!en),
    .adv   (pre_wrap),
    .limit (post_field),
    .wrap  (post_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      tick <= 1'b0;
      sclk <= 1'b0;
    end else begin
      tick <= post_wrap;
      sclk <= sclk ^ post_wrap;
    end
  end
endmodule

// File: rtl/spi_clk_divider_chk.sv
module spi_clk_divider_chk #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned POST_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [PRE_W-1:0]  pre_field,
  input logic [POST_W-1:0] post_field,
  input logic              tick,
  input logic              sclk
);
  localparam int unsigned GAP_W = PRE_W + POST_W;

  logic [PRE_W-2:0] ph;
  logic [GAP_W-1:0] exp_gap;
  logic [GAP_W-1:0] gap;

  always_comb begin
    ph = pre_field[PRE_W-1:1];
    if (ph == '0) ph = 1;
    exp_gap = GAP_W'((GAP_W'(post_field) + 1) * GAP_W'(ph));
  end

  // Enabled edges since enabling or since the last tick
  always_ff @(posedge clk) begin
    if (rst || !en) gap <= '0;
    else if (tick) gap <= 1;
    else gap <= gap + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !tick && !sclk);

  // R2
  disable_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick && !sclk);

  // R3
  tick_interval_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tick) |-> gap == exp_gap);

  // R3
  no_late_tick_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> gap <= exp_gap);

  // R4
  toggle_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> ((sclk != $past(sclk)) == tick));

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tick && exp_gap > 1) |=> !tick);
endmodule

bind spi_clk_divider spi_clk_divider_chk #(.PRE_W(PRE_W), .POST_W(POST_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .pre_field  (pre_field),
  .post_field (post_field),
  .tick       (tick),
  .sclk       (sclk)
);

// File: tb/spi_clk_divider_test.sv
module spi_clk_divider_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [7:0] pre_field = 8'd2;
  logic [7:0] post_field = 8'd0;
  logic       tick;
  logic       sclk;
  int         errors = 0;
  int         checks = 0;
  int         cyc = 0;

  always #2 clk = ~clk;

  spi_clk_divider uut (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .pre_field  (pre_field),
    .post_field (post_field),
    .tick       (tick),
    .sclk       (sclk)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog R3: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int half_of(input int pre, input int post);
    int p;
    p = pre & 254;
    if (p < 2) p = 2;
    return (post + 1) * p / 2;
  endfunction

  task automatic check(input string req, input logic act_t, input logic exp_t,
                       input logic act_s, input logic exp_s);
    checks = checks + 1;
    if (act_t !== exp_t || act_s !== exp_s) begin
      errors = errors + 1;
      $display("FAIL %s: actual tick=%b sclk=%b expected tick=%b sclk=%b",
               req, act_t, act_s, exp_t, exp_s);
    end
  endtask

  // Enable with the given fields and check each of n_cyc enabled edges
  task automatic run_cfg(input int pre, input int post, input int n_cyc, input string req);
    int h;
    h = half_of(pre, post);
    @(negedge clk);
    en = 1'b0;
    pre_field = 8'(pre);
    post_field = 8'(post);
    @(negedge clk);
    en = 1'b1;
    for (int k = 1; k <= n_cyc; k++) begin
      @(negedge clk);
      check(req, tick, (k % h) == 0, sclk, ((k / h) % 2) == 1);
    end
  endtask

  task automatic stop_check(input string req);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(req, tick, 1'b0, sclk, 1'b0);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", tick, 1'b0, sclk, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", tick, 1'b0, sclk, 1'b0);

    // R5 sweep of every raw prescaler with post 0
    for (int p = 0; p < 256; p++)
      run_cfg(p, 0, 2 * half_of(p, 0) + 2, "R5");
    stop_check("R2");

    // R6 sweep of every post value with minimum prescaler (R7 at post 0)
    for (int q = 0; q < 256; q++)
      run_cfg(2, q, 2 * half_of(2, q) + 2, (q == 0) ? "R7" : "R6");
    stop_check("R2");

    // R7 minimum ratio using raw prescaler 3
    run_cfg(3, 0, 8, "R7");

    // R4 mixed fields, several full periods
    run_cfg(7, 3, 6 * half_of(7, 3) + 1, "R4");
    run_cfg(10, 2, 6 * half_of(10, 2) + 1, "R3");

    // R9 drop enable while sclk is high, then restart
    run_cfg(10, 0, 7, "R9");
    stop_check("R2");
    run_cfg(10, 0, 12, "R9");
    stop_check("R2");

    // R8 maximum ratio, first tick after 32512 cycles
    run_cfg(255, 255, half_of(255, 255) + 2, "R8");
    stop_check("R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule